// File: doc/BRIEF.md
# Threshold Timer Channel Bank

This block holds a configurable number of independent timer channels behind one small register port. Each channel watches its own slow input signal, brings it into the system clock domain, and counts either its rising or its falling transitions. When the count equals a programmed limit the channel signals a match. It then either starts over from zero (repeating mode) or freezes and disarms itself (single-run mode).

A match produces an interrupt, either as a single system-clock pulse or as a sticky level that software must acknowledge. A channel may also act as a watchdog. Software then has to write a fixed service key before the count reaches its limit. If it fails to, the channel raises a reset request instead of an interrupt. The limit may be changed while the channel counts, and the running count can be read at any time without side effects.

Registers are addressed as `{channel, offset}`. The offset is the low 3 bits: 0 control, 1 limit, 2 count (read-only), 3 status, 4 service. In the control word, bit 0 is run, bit 1 selects single-run, bit 2 selects falling-edge counting, bit 3 selects level interrupts and bit 4 selects watchdog mode.

Top module: `tmr_bank`

## Requirements
- R1: After reset every channel reads control 0, limit 0, count 0 and status 0, and `irq` and `wdog_req` are low.
- R2: While control bit 0 is set, the count rises by one for each input transition of the selected kind: rising when bit 2 is 0, falling when bit 2 is 1. While bit 0 is clear, transitions leave the count unchanged.
- R3: Reading any register, including the count at offset 2, changes no channel state.
- R4: A match occurs while running when the count equals a nonzero limit. A limit of 0 never matches. In repeating mode (bit 1 = 0) the count reads 0 on the cycle after a match, and counting continues from there.
- R5: In single-run mode (bit 1 = 1) a match freezes the count at the limit and clears control bit 0.
- R6: With control bit 3 = 0, each match drives `irq` high for exactly one system clock cycle, one cycle after the match.
- R7: Every non-watchdog match sets status bit 0. With control bit 3 = 1, `irq` follows status bit 0. That bit clears only when 1 is written to status bit 0. A write of 0 has no effect, and a match in the same cycle as the clear wins.
- R8: A write to the limit at offset 1 takes effect at the next comparison, even while the channel runs.
- R9: With control bit 4 set, writing the key 0x5A3C to offset 4 clears the count, and any other value is ignored. A match raises `wdog_req` and leaves `irq` and status untouched. `wdog_req` stays high until the control register is written.
- R10: Any write to the control register clears that channel's count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_in | input | NUM_CH | Per-channel counting input, asynchronous |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Channel index above a 3-bit register offset |
| reg_wdata | input | CNT_W | Write data |
| reg_rdata | output | CNT_W | Combinational read data for `reg_addr` |
| irq | output | NUM_CH | Per-channel interrupt |
| wdog_req | output | NUM_CH | Per-channel watchdog reset request |

## Verification
The bench targets the following corner cases:
- Falling-edge polarity: the input is raised with falling counting selected and must not count. A design that ignored polarity would count on that rising transition.
- Pulse mode: the number of high `irq` cycles is counted per match. A level leaking into pulse mode, or a doubled pulse, shows up as a miscount.
- Live limit changes: the limit is raised past and lowered onto the running count. A design that latched the limit at start would match at the stale value.
- Watchdog service: a wrong key and the correct key are both tried. Accepting any key clears the count when it must not, and a watchdog match that also raised `irq` is caught.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

   localparam int OFF_W  = 3;
   localparam int CTRL_W = 5;

   typedef enum logic [OFF_W-1:0] {
      OFF_CTRL = 3'd0,
      OFF_LIM  = 3'd1,
      OFF_CNT  = 3'd2,
      OFF_STAT = 3'd3,
      OFF_SVC  = 3'd4
   } tmr_off_e;

   // packed MSB first: bit4 watchdog .. bit0 run
   typedef struct packed {
      logic wdog;
      logic level;
      logic falling;
      logic single;
      logic run;
   } tmr_ctrl_t;

endpackage

// File: rtl/tmr_sync_edge.sv
module tmr_sync_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic raw_in,
   input  logic falling,
   output logic edge_o
);
   localparam int HIST = STAGES;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("tmr_sync_edge: STAGES must be at least 2");
      end
   endgenerate

   logic [HIST:0] shreg;

   always_ff @(posedge clk) begin
      if (!rst_n) shreg <= '0;
      else        shreg <= {shreg[HIST-1:0], raw_in};
   end

   logic now_v, was_v;
   assign now_v = shreg[HIST-1];
   assign was_v = shreg[HIST];

   generate
      if (1) begin : g_edge_sel
         always_comb begin
            if (falling) edge_o = was_v & ~now_v;
            else         edge_o = now_v & ~was_v;
         end
      end
   endgenerate
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
   import tmr_pkg::*;
#(
   parameter int               CNT_W   = 16,
   parameter int               STAGES  = 2,
   parameter logic [CNT_W-1:0] SVC_KEY = 'h5A3C
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             ctrl_wr,
   input  tmr_ctrl_t        ctrl_wdata,
   input  logic             lim_wr,
   input  logic             stat_w1c,
   input  logic             svc_wr,
   input  logic [CNT_W-1:0] wdata,
   output tmr_ctrl_t        ctrl_q,
   output logic [CNT_W-1:0] lim_q,
   output logic [CNT_W-1:0] cnt_q,
   output logic             stat_q,
   output logic             irq_o,
   output logic             wdreq_o
);
   logic tick_edge;
   logic hit;
   logic svc_ok;
   logic pulse_q;
   logic wdreq_q;

   tmr_sync_edge #(.STAGES(STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .raw_in (tick),
      .falling(ctrl_q.falling),
      .edge_o (tick_edge)
   );

   assign hit    = ctrl_q.run && (lim_q != '0) && (cnt_q == lim_q);
   assign svc_ok = svc_wr && ctrl_q.wdog && (wdata == SVC_KEY);

   always_ff @(posedge clk) begin
      if (!rst_n)                cnt_q <= '0;
      else if (ctrl_wr || svc_ok) cnt_q <= '0;
      else if (hit) begin
         if (!ctrl_q.single)     cnt_q <= '0;
      end
      else if (ctrl_q.run && tick_edge) cnt_q <= cnt_q + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                      ctrl_q <= '0;
      else if (ctrl_wr)                ctrl_q <= ctrl_wdata;
      else if (hit && ctrl_q.single)   ctrl_q.run <= 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      lim_q <= '0;
      else if (lim_wr) lim_q <= wdata;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pulse_q <= 1'b0;
         stat_q  <= 1'b0;
         wdreq_q <= 1'b0;
      end else begin
         pulse_q <= hit && !ctrl_q.wdog;
         stat_q  <= (hit && !ctrl_q.wdog) || (stat_q && !stat_w1c);
         if (ctrl_wr)                  wdreq_q <= 1'b0;
         else if (hit && ctrl_q.wdog)  wdreq_q <= 1'b1;
      end
   end

   generate
      if (1) begin : g_irq_style
         always_comb irq_o = ctrl_q.level ? stat_q : pulse_q;
      end
   endgenerate
   assign wdreq_o = wdreq_q;

   // R6: a pulse never lasts beyond one cycle
   a_r6_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_q |=> !pulse_q);

   // R5: single-run match halts the channel and freezes the count
   a_r5_single_halts: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && ctrl_q.single && !ctrl_wr && !svc_ok) |=> (!ctrl_q.run && $stable(cnt_q)));

   // R4: repeating match restarts from zero
   a_r4_repeat_restart: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && !ctrl_q.single && !ctrl_wr) |=> (cnt_q == '0));

   // R2: stopped channel does not count
   a_r2_idle_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl_q.run && !ctrl_wr && !svc_wr) |=> $stable(cnt_q));

   // R7: sticky status survives until acknowledged
   a_r7_status_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_q && !stat_w1c) |=> stat_q);

   // R9: watchdog match requests reset and raises no interrupt pulse
   a_r9_wd_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && ctrl_q.wdog && !ctrl_wr) |=> (wdreq_o && !pulse_q));
endmodule

// File: rtl/tmr_regif.sv
module tmr_regif
   import tmr_pkg::*;
#(
   parameter int NUM_CH = 2,
   parameter int CNT_W  = 16,
   parameter int CH_W   = 1
) (
   input  logic                         reg_wr,
   input  logic [CH_W+OFF_W-1:0]        reg_addr,
   input  logic [CNT_W-1:0]             reg_wdata,
   output logic [CNT_W-1:0]             reg_rdata,
   output logic [NUM_CH-1:0]            ctrl_wr,
   output logic [NUM_CH-1:0]            lim_wr,
   output logic [NUM_CH-1:0]            stat_w1c,
   output logic [NUM_CH-1:0]            svc_wr,
   input  tmr_ctrl_t [NUM_CH-1:0]       ctrl_all,
   input  logic [NUM_CH-1:0][CNT_W-1:0] lim_all,
   input  logic [NUM_CH-1:0][CNT_W-1:0] cnt_all,
   input  logic [NUM_CH-1:0]            stat_all
);
   logic [CH_W-1:0]  sel_ch;
   logic [OFF_W-1:0] sel_off;
   assign sel_ch  = reg_addr[CH_W+OFF_W-1:OFF_W];
   assign sel_off = reg_addr[OFF_W-1:0];

   for (genvar c = 0; c < NUM_CH; c++) begin : g_dec
      logic hit_ch;
      assign hit_ch      = reg_wr && (sel_ch == CH_W'(c));
      assign ctrl_wr[c]  = hit_ch && (sel_off == OFF_CTRL);
      assign lim_wr[c]   = hit_ch && (sel_off == OFF_LIM);
      assign stat_w1c[c] = hit_ch && (sel_off == OFF_STAT) && reg_wdata[0];
      assign svc_wr[c]   = hit_ch && (sel_off == OFF_SVC);
   end

   always_comb begin
      reg_rdata = '0;
      for (int c = 0; c < NUM_CH; c++) begin
         if (sel_ch == CH_W'(c)) begin
            case (sel_off)
               OFF_CTRL: reg_rdata = CNT_W'(ctrl_all[c]);
               OFF_LIM:  reg_rdata = lim_all[c];
               OFF_CNT:  reg_rdata = cnt_all[c];
               OFF_STAT: reg_rdata = CNT_W'(stat_all[c]);
               default:  reg_rdata = '0;
            endcase
         end
      end
   end
endmodule

// File: rtl/tmr_bank.sv
module tmr_bank
   import tmr_pkg::*;
#(
   parameter int               NUM_CH      = 2,
   parameter int               CNT_W       = 16,
   parameter int               SYNC_STAGES = 2,
   parameter logic [CNT_W-1:0] SVC_KEY     = 'h5A3C,
   localparam int              CH_W        = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
   localparam int              ADDR_W      = CH_W + OFF_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] tick_in,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [CNT_W-1:0]  reg_wdata,
   output logic [CNT_W-1:0]  reg_rdata,
   output logic [NUM_CH-1:0] irq,
   output logic [NUM_CH-1:0] wdog_req
);
   generate
      if (CNT_W < CTRL_W) begin : g_bad_width
         $error("tmr_bank: CNT_W must hold the control word");
      end
      if (NUM_CH < 1) begin : g_bad_count
         $error("tmr_bank: NUM_CH must be at least 1");
      end
   endgenerate

   logic [NUM_CH-1:0]            ctrl_wr, lim_wr, stat_w1c, svc_wr;
   tmr_ctrl_t [NUM_CH-1:0]       ctrl_all;
   logic [NUM_CH-1:0][CNT_W-1:0] lim_all, cnt_all;
   logic [NUM_CH-1:0]            stat_all;

   tmr_regif #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .CH_W(CH_W)) u_regif (
      .reg_wr   (reg_wr),
      .reg_addr (reg_addr),
      .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata),
      .ctrl_wr  (ctrl_wr),
      .lim_wr   (lim_wr),
      .stat_w1c (stat_w1c),
      .svc_wr   (svc_wr),
      .ctrl_all (ctrl_all),
      .lim_all  (lim_all),
      .cnt_all  (cnt_all),
      .stat_all (stat_all)
   );

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      tmr_channel #(.CNT_W(CNT_W), .STAGES(SYNC_STAGES), .SVC_KEY(SVC_KEY)) u_ch (
         .clk       (clk),
         .rst_n     (rst_n),
         .tick      (tick_in[c]),
         .ctrl_wr   (ctrl_wr[c]),
         .ctrl_wdata(tmr_ctrl_t'(reg_wdata[CTRL_W-1:0])),
         .lim_wr    (lim_wr[c]),
         .stat_w1c  (stat_w1c[c]),
         .svc_wr    (svc_wr[c]),
         .wdata     (reg_wdata),
         .ctrl_q    (ctrl_all[c]),
         .lim_q     (lim_all[c]),
         .cnt_q     (cnt_all[c]),
         .stat_q    (stat_all[c]),
         .irq_o     (irq[c]),
         .wdreq_o   (wdog_req[c])
      );
   end
endmodule

// File: tb/sim_tmr_bank.sv
`timescale 1ns/1ps
module sim_tmr_bank;
   localparam int NCH = 2;

   logic        clk = 0;
   logic        rst_n = 0;
   logic [1:0]  tick_in = '0;
   logic        reg_wr = 0;
   logic [3:0]  reg_addr = '0;
   logic [15:0] reg_wdata = '0;
   logic [15:0] reg_rdata;
   logic [1:0]  irq, wdog_req;

   always #2 clk = ~clk;

   tmr_bank u0 (.clk(clk), .rst_n(rst_n), .tick_in(tick_in), .reg_wr(reg_wr),
                .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
                .irq(irq), .wdog_req(wdog_req));

   int n_chk = 0, n_bad = 0;
   string req_tag = "R1";

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // behavioural reference model
   int s1[NCH], s2[NCH], s3[NCH];
   int run[NCH], one[NCH], fal[NCH], lvl[NCH], wd[NCH];
   int lim[NCH], cnt[NCH], pls[NCH], sts[NCH], wdr[NCH];
   int irq_cycles[NCH];

   function automatic int model_read(input int a);
      int ch = a / 8, off = a % 8;
      if (ch >= NCH) return 0;
      case (off)
         0: return run[ch] + 2*one[ch] + 4*fal[ch] + 8*lvl[ch] + 16*wd[ch];
         1: return lim[ch];
         2: return cnt[ch];
         3: return sts[ch];
         default: return 0;
      endcase
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int c = 0; c < NCH; c++) begin
            s1[c]=0; s2[c]=0; s3[c]=0; run[c]=0; one[c]=0; fal[c]=0; lvl[c]=0; wd[c]=0;
            lim[c]=0; cnt[c]=0; pls[c]=0; sts[c]=0; wdr[c]=0;
         end
      end else begin
         for (int c = 0; c < NCH; c++) begin
            int tr, matched, mine, off, clr_cnt, cw;
            tr = fal[c] ? (s3[c]==1 && s2[c]==0) : (s2[c]==1 && s3[c]==0);
            matched = run[c] && lim[c] != 0 && cnt[c] == lim[c];
            mine = reg_wr && (reg_addr[3] == c[0]);
            off  = reg_addr[2:0];
            cw = mine && off == 0;
            clr_cnt = cw || (mine && off == 4 && wd[c] && reg_wdata == 16'h5A3C);
            pls[c] = matched && !wd[c];
            if (matched && !wd[c]) sts[c] = 1;
            else if (mine && off == 3 && reg_wdata[0]) sts[c] = 0;
            if (cw) wdr[c] = 0;
            else if (matched && wd[c]) wdr[c] = 1;
            if (clr_cnt) cnt[c] = 0;
            else if (matched) begin if (!one[c]) cnt[c] = 0; end
            else if (run[c] && tr) cnt[c] = (cnt[c] + 1) % 65536;
            if (cw) begin
               run[c]=reg_wdata[0]; one[c]=reg_wdata[1]; fal[c]=reg_wdata[2];
               lvl[c]=reg_wdata[3]; wd[c]=reg_wdata[4];
            end else if (matched && one[c]) run[c] = 0;
            if (mine && off == 1) lim[c] = reg_wdata;
            s3[c] = s2[c]; s2[c] = s1[c]; s1[c] = tick_in[c];
         end
      end
      #1;
      if (rst_n) begin
         for (int c = 0; c < NCH; c++) begin
            int ei;
            ei = lvl[c] ? sts[c] : pls[c];
            chk({req_tag, " irq"}, irq[c], ei);
            chk({req_tag, " wdog_req"}, wdog_req[c], wdr[c]);
            if (irq[c]) irq_cycles[c]++;
         end
         chk({req_tag, " rdata"}, reg_rdata, model_read(reg_addr));
      end
   end

   task automatic wr(input int a, input int d);
      @(negedge clk); reg_wr = 1; reg_addr = a[3:0]; reg_wdata = d[15:0];
      @(negedge clk); reg_wr = 0;
   endtask

   task automatic rd(input int a, output int v);
      @(negedge clk); reg_addr = a[3:0]; #1 v = reg_rdata;
   endtask

   task automatic edges(input int c, input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); tick_in[c] = 1; repeat (3) @(negedge clk);
         tick_in[c] = 0; repeat (3) @(negedge clk);
      end
      repeat (4) @(negedge clk);
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      int v, base;
      for (int c = 0; c < NCH; c++) irq_cycles[c] = 0;
      repeat (4) @(negedge clk);
      rst_n = 1;
      idle(2);
      // R1 reset state
      rd(0, v); chk("R1 ctrl", v, 0);
      rd(2, v); chk("R1 count", v, 0);
      chk("R1 irq", irq, 0);
      chk("R1 wdog_req", wdog_req, 0);

      // R2 rising count, stopped channel ignores edges
      req_tag = "R2";
      wr(1, 100); wr(0, 1);
      edges(0, 5);
      rd(2, v); chk("R2 rising count", v, 5);
      req_tag = "R10";
      wr(0, 0);
      rd(2, v); chk("R10 ctrl write clears count", v, 0);
      req_tag = "R2";
      edges(0, 3);
      rd(2, v); chk("R2 stopped no count", v, 0);
      // R2 falling polarity on channel 1
      wr(9, 100); wr(8, 5);
      @(negedge clk); tick_in[1] = 1; idle(6);
      rd(10, v); chk("R2 falling ignores rise", v, 0);
      tick_in[1] = 0; idle(6);
      rd(10, v); chk("R2 falling counts fall", v, 1);

      // R3 reads have no side effect
      req_tag = "R3";
      rd(10, v); rd(8, v); rd(10, v); chk("R3 count unchanged by reads", v, 1);

      // R4 / R6 repeating pulse
      req_tag = "R4";
      wr(0, 0); wr(1, 3); wr(0, 1);
      base = irq_cycles[0];
      edges(0, 3);
      chk("R6 one pulse cycle", irq_cycles[0] - base, 1);
      rd(2, v); chk("R4 restart at zero", v, 0);
      edges(0, 2);
      rd(2, v); chk("R4 keeps counting", v, 2);
      wr(3, 1);

      // R5 single-run on channel 1
      req_tag = "R5";
      wr(8, 0); wr(9, 2); wr(8, 3);
      edges(1, 4);
      rd(10, v); chk("R5 frozen at limit", v, 2);
      rd(8, v);  chk("R5 run bit cleared", v, 2);

      // R7 level interrupt
      req_tag = "R7";
      wr(11, 1); wr(8, 9);
      edges(1, 2); idle(10);
      chk("R7 level held", irq[1], 1);
      rd(11, v); chk("R7 status set", v, 1);
      wr(11, 0);
      chk("R7 write zero keeps level", irq[1], 1);
      wr(11, 1);
      chk("R7 cleared by write one", irq[1], 0);

      // R8 live limit changes
      req_tag = "R8";
      wr(0, 0); wr(1, 10); wr(0, 1);
      edges(0, 4);
      wr(1, 6);
      base = irq_cycles[0];
      edges(0, 2);
      chk("R8 lowered limit matches", irq_cycles[0] - base, 1);
      wr(0, 0); wr(1, 3); wr(0, 1);
      edges(0, 2); wr(1, 5);
      base = irq_cycles[0];
      edges(0, 1);
      chk("R8 raised limit no early match", irq_cycles[0] - base, 0);
      rd(2, v); chk("R8 count passes old limit", v, 3);
      edges(0, 2);
      chk("R8 raised limit matches", irq_cycles[0] - base, 1);

      // R9 watchdog
      req_tag = "R9";
      wr(0, 0); wr(3, 1); wr(1, 4); wr(0, 17);
      edges(0, 3);
      wr(4, 16'h5A3C);
      rd(2, v); chk("R9 key clears count", v, 0);
      edges(0, 3);
      wr(4, 16'h1234);
      rd(2, v); chk("R9 wrong key ignored", v, 3);
      base = irq_cycles[0];
      edges(0, 1);
      chk("R9 reset request", wdog_req[0], 1);
      chk("R9 no irq", irq_cycles[0] - base, 0);
      rd(3, v); chk("R9 status untouched", v, 0);
      wr(0, 0);
      chk("R9 request cleared by ctrl write", wdog_req[0], 0);

      idle(4);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule